// File: doc/BRIEF.md
# Snooping MSI Cache Controller

This block is the controller of one private, direct-mapped, write-back data cache that stays coherent with peer caches on a shared broadcast bus. Coherence follows a write-invalidate protocol in which every line is Modified (sole, writable and dirty copy), Shared (clean and readable) or Invalid. Each line holds a block of two 32-bit words. The CPU side is a simple load/store port with a stall output. The bus side has a request/grant/done handshake for the controller's own transactions and a snoop input on which every transaction placed on the bus is observed, including the controller's own.

CPU hits complete in the cycle they are presented. A miss first writes back a dirty line that holds a different block, then issues a read miss or a write miss. The CPU stays stalled until the fill has been written into the line. The snoop side answers in the same cycle: when it holds the requested block as Modified, it raises the abort line that tells memory to stand back and drives the block on its supply bus. It then downgrades the line to Shared on a read miss, or drops it to Invalid on a write miss. Arbitration, memory and upper cache levels sit outside the block.

Addresses at the CPU port are word addresses: bit 0 selects the word within the block (0 = bits 31:0 of the 64-bit block, 1 = bits 63:32). The next log2(LINES) bits are the line index and the rest is the tag. Bus and snoop addresses are block addresses laid out as {tag, index}. Bus operation codes are 0 none, 1 read miss, 2 write miss and 3 write back.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. With no CPU request, the outputs cpu_stall, bus_req, snp_abort and snp_supply are low, so the first access to any block misses.
- R2: A CPU read that misses raises cpu_stall and issues op 1 (read miss) with the requested block address. The line is filled from bus_rdata in Shared state, and the requested word is returned the cycle after bus_done.
- R3: A CPU write to a line in Invalid state, or to a line whose tag differs, issues op 2 (write miss). So does a write to a line in Shared state. The filled block has the written word merged in, and the line ends Modified.
- R4: If the indexed line is Modified with a different tag, op 3 (write back) carrying that block's address and data is issued and completed before the miss request.
- R5: A read to a Shared or Modified line with a matching tag is a hit, and so is a write to a Modified line with a matching tag. A hit keeps cpu_stall low in the cycle of the request, returns read data combinationally and raises no bus request.
- R6: A foreign snooped read miss (op 1) to a Modified block raises snp_abort and snp_supply in the same cycle, with the block on snp_supply_data. The line becomes Shared, so a later CPU write to it issues a write miss.
- R7: A foreign snooped write miss (op 2) to a Shared or Modified block leaves the line Invalid. A Modified block is first supplied with snp_abort. A later CPU read of that block misses.
- R8: A foreign snoop in the same cycle as a CPU request stalls the CPU for that cycle, even if the request would hit.
- R9: A snoop whose snp_src equals the NODE_ID parameter is ignored: no abort, no supply and no change of line state.
- R10: Once the controller's own bus transaction is granted, cpu_stall stays high until bus_done and the fill have completed.
- R11: A snoop whose tag does not match the indexed line, or that finds an Invalid line, or that carries op 3, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until cpu_stall is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | WADDR_W | Word address {tag, index, word select} |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while cpu_req is high and cpu_stall is low |
| cpu_stall | output | 1 | CPU must hold its request |
| bus_req | output | 1 | Own bus transaction requested or in flight |
| bus_op | output | 2 | Own operation: 1 read miss, 2 write miss, 3 write back |
| bus_addr | output | WADDR_W-1 | Block address of own transaction |
| bus_wdata | output | 64 | Block data for a write back |
| bus_gnt | input | 1 | Bus grant for the pending request |
| bus_done | input | 1 | Own transaction complete; bus_rdata valid for misses |
| bus_rdata | input | 64 | Fill block |
| snp_valid | input | 1 | A bus transaction is being observed |
| snp_src | input | SRC_W | Identity of the transaction's issuer |
| snp_op | input | 2 | Observed operation code |
| snp_addr | input | WADDR_W-1 | Observed block address |
| snp_abort | output | 1 | Memory must not answer; this cache supplies |
| snp_supply | output | 1 | snp_supply_data carries the dirty block |
| snp_supply_data | output | 64 | Dirty block supplied or written back |

## Verification
A wrong line state shows up at the ports at the next access to that index. A line wrongly left Shared makes a later write raise a write miss where a silent hit was due. A line wrongly left Modified makes a later foreign read see an abort and a supply where none should appear. A wrong tag or wrong merged data appears as a wrong read word the first time the block is read, or as a wrong write-back payload when the line is evicted. For this reason the bench keeps its own line and memory image and compares stall, bus operations, supplies and read data in every cycle of every access.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int WORD_W = 32;
  localparam int BLK_W  = 2 * WORD_W;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_RDMISS = 2'd1,
    OP_WRMISS = 2'd2,
    OP_WBACK  = 2'd3
  } bus_op_e;

  // Word select: 0 = low half of the block, 1 = high half.
  function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] blk,
                                                  input logic sel);
    return sel ? blk[BLK_W-1:WORD_W] : blk[WORD_W-1:0];
  endfunction

  function automatic logic [BLK_W-1:0] put_word(input logic [BLK_W-1:0] blk,
                                                input logic sel,
                                                input logic [WORD_W-1:0] w);
    return sel ? {w, blk[WORD_W-1:0]} : {blk[BLK_W-1:WORD_W], w};
  endfunction
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  // CPU-side read port
  input  logic [IDX_W-1:0] a_idx,
  output line_st_e         a_state,
  output logic [TAG_W-1:0] a_tag,
  output logic [BLK_W-1:0] a_data,
  // snoop-side read port
  input  logic [IDX_W-1:0] b_idx,
  output line_st_e         b_state,
  output logic [TAG_W-1:0] b_tag,
  output logic [BLK_W-1:0] b_data,
  // snoop state update (wins over the CPU update)
  input  logic             s_we,
  input  line_st_e         s_state,
  // CPU-side line update
  input  logic             c_we,
  input  line_st_e         c_state,
  input  logic [TAG_W-1:0] c_tag,
  input  logic [BLK_W-1:0] c_data
);
  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [BLK_W-1:0] dat_q [LINES];

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = dat_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = dat_q[b_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LN_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (c_we) begin
        st_q[a_idx]  <= c_state;
        tag_q[a_idx] <= c_tag;
        dat_q[a_idx] <= c_data;
      end
      if (s_we) begin
        st_q[b_idx] <= s_state;
      end
    end
  end
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W   = 10,
  parameter int SRC_W   = 2,
  parameter int NODE_ID = 1
) (
  input  logic             snp_valid,
  input  logic [SRC_W-1:0] snp_src,
  input  logic [1:0]       snp_op,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_e         line_state,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [BLK_W-1:0] line_data,
  output logic             foreign,
  output logic             abort,
  output logic             supply,
  output logic [BLK_W-1:0] supply_data,
  output logic             upd_we,
  output line_st_e         upd_state
);
  logic hold;

  assign foreign     = snp_valid && (snp_src != SRC_W'(NODE_ID));
  assign hold        = foreign && (line_state != LN_INV) && (line_tag == snp_tag);
  assign supply_data = line_data;

  always_comb begin
    abort     = 1'b0;
    supply    = 1'b0;
    upd_we    = 1'b0;
    upd_state = line_state;
    if (hold) begin
      if (snp_op == OP_RDMISS && line_state == LN_MOD) begin
        abort     = 1'b1;
        supply    = 1'b1;
        upd_we    = 1'b1;
        upd_state = LN_SHR;
      end else if (snp_op == OP_WRMISS) begin
        abort     = (line_state == LN_MOD);
        supply    = (line_state == LN_MOD);
        upd_we    = 1'b1;
        upd_state = LN_INV;
      end
    end
  end
endmodule

// File: rtl/msi_miss_fsm.sv
module msi_miss_fsm
  import msi_pkg::*;
#(
  parameter int TAG_W = 10,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [TAG_W-1:0]       cpu_tag,
  input  logic [IDX_W-1:0]       cpu_idx,
  input  logic                   cpu_sel,
  input  logic [WORD_W-1:0]      cpu_wdata,
  output logic                   cpu_stall,
  output logic [WORD_W-1:0]      cpu_rdata,
  input  line_st_e               line_state,
  input  logic [TAG_W-1:0]       line_tag,
  input  logic [BLK_W-1:0]       line_data,
  input  logic                   foreign,
  output logic                   bus_req,
  output bus_op_e                bus_op,
  output logic [TAG_W+IDX_W-1:0] bus_addr,
  output logic [BLK_W-1:0]       bus_wdata,
  input  logic                   bus_gnt,
  input  logic                   bus_done,
  input  logic [BLK_W-1:0]       bus_rdata,
  output logic                   c_we,
  output line_st_e               c_state,
  output logic [TAG_W-1:0]       c_tag,
  output logic [BLK_W-1:0]       c_data,
  output logic                   victim_dirty
);
  typedef enum logic [2:0] {F_IDLE, F_WB_REQ, F_WB_WAIT, F_MS_REQ, F_MS_WAIT} fsm_e;

  fsm_e fsm_q, fsm_d;
  logic tag_eq, hit_rd, hit_wr, serve;

  assign tag_eq       = (line_tag == cpu_tag);
  assign hit_rd       = cpu_req && !cpu_we && tag_eq && (line_state != LN_INV);
  assign hit_wr       = cpu_req && cpu_we && tag_eq && (line_state == LN_MOD);
  assign serve        = (fsm_q == F_IDLE) && !foreign && (hit_rd || hit_wr);
  assign victim_dirty = (line_state == LN_MOD) && !tag_eq;
  assign cpu_stall    = cpu_req && !serve;
  assign cpu_rdata    = pick_word(line_data, cpu_sel);

  always_comb begin
    fsm_d     = fsm_q;
    bus_req   = 1'b0;
    bus_op    = OP_NONE;
    bus_addr  = {cpu_tag, cpu_idx};
    bus_wdata = '0;
    c_we      = 1'b0;
    c_state   = line_state;
    c_tag     = line_tag;
    c_data    = line_data;
    unique case (fsm_q)
      F_IDLE: begin
        if (serve && hit_wr) begin
          c_we    = 1'b1;
          c_state = LN_MOD;
          c_data  = put_word(line_data, cpu_sel, cpu_wdata);
        end else if (cpu_req && !foreign && !(hit_rd || hit_wr)) begin
          fsm_d = victim_dirty ? F_WB_REQ : F_MS_REQ;
        end
      end
      F_WB_REQ, F_WB_WAIT: begin
        bus_req   = (fsm_q == F_WB_WAIT) || victim_dirty;
        bus_op    = bus_req ? OP_WBACK : OP_NONE;
        bus_addr  = {line_tag, cpu_idx};
        bus_wdata = line_data;
        if (fsm_q == F_WB_REQ) begin
          if (!victim_dirty) fsm_d = F_MS_REQ;
          else if (bus_gnt)  fsm_d = F_WB_WAIT;
        end else if (bus_done) begin
          c_we    = 1'b1;
          c_state = LN_INV;
          fsm_d   = F_MS_REQ;
        end
      end
      F_MS_REQ, F_MS_WAIT: begin
        bus_req = 1'b1;
        bus_op  = cpu_we ? OP_WRMISS : OP_RDMISS;
        if (fsm_q == F_MS_REQ) begin
          if (bus_gnt) fsm_d = F_MS_WAIT;
        end else if (bus_done) begin
          c_we    = 1'b1;
          c_state = cpu_we ? LN_MOD : LN_SHR;
          c_tag   = cpu_tag;
          c_data  = cpu_we ? put_word(bus_rdata, cpu_sel, cpu_wdata) : bus_rdata;
          fsm_d   = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fsm_q <= F_IDLE;
    else        fsm_q <= fsm_d;
  end
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int WADDR_W = 14,
  parameter int LINES   = 8,
  parameter int SRC_W   = 2,
  parameter int NODE_ID = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [WADDR_W-1:0] cpu_addr,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_rdata,
  output logic               cpu_stall,
  output logic               bus_req,
  output logic [1:0]         bus_op,
  output logic [WADDR_W-2:0] bus_addr,
  output logic [63:0]        bus_wdata,
  input  logic               bus_gnt,
  input  logic               bus_done,
  input  logic [63:0]        bus_rdata,
  input  logic               snp_valid,
  input  logic [SRC_W-1:0]   snp_src,
  input  logic [1:0]         snp_op,
  input  logic [WADDR_W-2:0] snp_addr,
  output logic               snp_abort,
  output logic               snp_supply,
  output logic [63:0]        snp_supply_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = WADDR_W - 1 - IDX_W;

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  logic             cpu_sel;

  assign cpu_sel = cpu_addr[0];
  assign cpu_idx = cpu_addr[IDX_W:1];
  assign cpu_tag = cpu_addr[WADDR_W-1:IDX_W+1];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[WADDR_W-2:IDX_W];

  line_st_e         a_state, b_state, s_state, c_state;
  logic [TAG_W-1:0] a_tag, b_tag, c_tag;
  logic [BLK_W-1:0] a_data, b_data, c_data;
  logic             s_we, c_we, foreign;
  logic             evt_victim_dirty;
  bus_op_e          bus_op_w;

  assign bus_op = bus_op_w;

  msi_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cpu_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_idx(snp_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .s_we(s_we), .s_state(s_state),
    .c_we(c_we), .c_state(c_state), .c_tag(c_tag), .c_data(c_data)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .SRC_W(SRC_W), .NODE_ID(NODE_ID)) u_snoop (
    .snp_valid(snp_valid), .snp_src(snp_src), .snp_op(snp_op), .snp_tag(snp_tag),
    .line_state(b_state), .line_tag(b_tag), .line_data(b_data),
    .foreign(foreign), .abort(snp_abort), .supply(snp_supply),
    .supply_data(snp_supply_data), .upd_we(s_we), .upd_state(s_state)
  );

  msi_miss_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag), .cpu_idx(cpu_idx),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
    .cpu_rdata(cpu_rdata),
    .line_state(a_state), .line_tag(a_tag), .line_data(a_data), .foreign(foreign),
    .bus_req(bus_req), .bus_op(bus_op_w), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .c_we(c_we), .c_state(c_state), .c_tag(c_tag), .c_data(c_data),
    .victim_dirty(evt_victim_dirty)
  );
endmodule

// File: rtl/msi_cache_sva.sv
module msi_cache_sva
  import msi_pkg::*;
#(
  parameter int SRC_W   = 2,
  parameter int NODE_ID = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_stall,
  input logic             bus_req,
  input logic [1:0]       bus_op,
  input logic             snp_valid,
  input logic [SRC_W-1:0] snp_src,
  input logic             snp_abort,
  input logic             snp_supply,
  input logic             victim_dirty
);
  p_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |-> !bus_req);

  p_supply_aborts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_abort);

  p_self_snoop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_src == SRC_W'(NODE_ID)) |-> (!snp_abort && !snp_supply));

  p_wback_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op != OP_WBACK) |-> !victim_dirty);

  p_snoop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && snp_valid && snp_src != SRC_W'(NODE_ID)) |-> cpu_stall);

  p_stall_in_flight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && bus_req) |-> cpu_stall);
endmodule

bind msi_cache_ctrl msi_cache_sva #(.SRC_W(SRC_W), .NODE_ID(NODE_ID)) u_sva (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_stall(cpu_stall),
  .bus_req(bus_req), .bus_op(bus_op), .snp_valid(snp_valid), .snp_src(snp_src),
  .snp_abort(snp_abort), .snp_supply(snp_supply), .victim_dirty(evt_victim_dirty)
);

// File: tb/test_msi_cache_ctrl.sv
module test_msi_cache_ctrl;
  localparam int WA    = 14;
  localparam int LINES = 8;
  localparam int IDXW  = 3;
  localparam int TAGW  = WA - 1 - IDXW;
  localparam int BAW   = WA - 1;
  localparam int ME    = 1;
  localparam int PEER  = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [WA-1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_stall, bus_req;
  logic [1:0] bus_op;
  logic [BAW-1:0] bus_addr;
  logic [63:0] bus_wdata, bus_rdata = '0;
  logic bus_gnt = 0, bus_done = 0;
  logic snp_valid = 0;
  logic [1:0] snp_src = '0, snp_op = '0;
  logic [BAW-1:0] snp_addr = '0;
  logic snp_abort, snp_supply;
  logic [63:0] snp_supply_data;

  always #5 clk = ~clk;

  msi_cache_ctrl #(.WADDR_W(WA), .LINES(LINES), .SRC_W(2), .NODE_ID(ME)) i_msi_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_src(snp_src), .snp_op(snp_op), .snp_addr(snp_addr),
    .snp_abort(snp_abort), .snp_supply(snp_supply), .snp_supply_data(snp_supply_data)
  );

  // Reference image: line state 0 Invalid, 1 Shared, 2 Modified.
  int          m_st  [LINES];
  logic [TAGW-1:0] m_tag [LINES];
  logic [63:0] m_dat [LINES];
  logic [63:0] mem [int];
  int nchk = 0, nfail = 0;

  typedef struct {
    logic [1:0]     op;
    logic [BAW-1:0] addr;
    logic [63:0]    data;
  } txn_t;
  txn_t expq[$];

  function automatic logic [63:0] mem_rd(int b);
    if (mem.exists(b)) return mem[b];
    return {32'(b) * 32'h0000_9E37 ^ 32'h5A5A_0000, 32'(b) + 32'h00C0_0000};
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic access(bit we, logic [WA-1:0] a, logic [31:0] wd);
    logic [IDXW-1:0] idx;
    logic [TAGW-1:0] tg;
    bit sel, hit, inflight, done_now;
    int cyc;
    txn_t cur, t;
    logic [31:0] expw;
    string rq;
    idx = a[IDXW:1]; tg = a[WA-1:IDXW+1]; sel = a[0];
    hit = (m_tag[idx] == tg) && (we ? (m_st[idx] == 2) : (m_st[idx] != 0));
    rq = hit ? "R5 hit" : (we ? "R3 write miss" : "R2 read miss");
    expq.delete();
    if (!hit) begin
      if (m_st[idx] == 2 && m_tag[idx] != tg) begin
        t.op = 2'd3; t.addr = {m_tag[idx], idx}; t.data = m_dat[idx];
        expq.push_back(t);
        mem[int'({m_tag[idx], idx})] = m_dat[idx];
      end
      t.op = we ? 2'd2 : 2'd1; t.addr = {tg, idx}; t.data = '0;
      expq.push_back(t);
      m_dat[idx] = mem_rd(int'({tg, idx}));
      m_tag[idx] = tg;
      m_st[idx]  = we ? 2 : 1;
    end
    if (we) begin
      m_dat[idx] = sel ? {wd, m_dat[idx][31:0]} : {m_dat[idx][63:32], wd};
      m_st[idx]  = 2;
    end
    expw = sel ? m_dat[idx][63:32] : m_dat[idx][31:0];

    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    chk(cpu_stall == !hit, {rq, " stall in request cycle"}, 64'(cpu_stall), 64'(!hit));
    if (hit) chk(!bus_req, "R5 no bus traffic on hit", 64'(bus_req), 0);
    inflight = 0; done_now = 0; cyc = 0;
    while (cpu_stall && cyc < 60) begin
      if (bus_req && !inflight && !done_now) begin
        chk(expq.size() != 0, "R4 unexpected bus request", 64'(bus_op), 0);
        if (expq.size() != 0) begin
          cur = expq.pop_front();
          chk(bus_op == cur.op, "R4 bus op order", 64'(bus_op), 64'(cur.op));
          chk(bus_addr == cur.addr, "R2 bus block address", 64'(bus_addr), 64'(cur.addr));
          if (cur.op == 2'd3)
            chk(bus_wdata == cur.data, "R4 write-back data", bus_wdata, cur.data);
        end
        bus_gnt = 1; inflight = 1;
      end
      @(negedge clk);
      bus_gnt = 0; bus_done = 0; done_now = 0;
      if (inflight) begin
        bus_done  = 1;
        bus_rdata = (cur.op == 2'd3) ? 64'd0 : mem_rd(int'(cur.addr));
        inflight  = 0; done_now = 1;
        #1;
        chk(cpu_stall, "R10 stall held until done", 64'(cpu_stall), 1);
      end else begin
        #1;
      end
      cyc++;
    end
    bus_done = 0;
    chk(cyc < 60, "R10 access completed", 64'(cyc), 60);
    chk(expq.size() == 0, "R4 all bus transactions issued", 64'(expq.size()), 0);
    if (!we) chk(cpu_rdata == expw, {rq, " read data"}, 64'(cpu_rdata), 64'(expw));
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic snoop(int src, logic [1:0] op, logic [BAW-1:0] blk, string rq);
    logic [IDXW-1:0] idx;
    bit match, sup;
    idx = blk[IDXW-1:0];
    match = (src != ME) && (m_st[idx] != 0) && (m_tag[idx] == blk[BAW-1:IDXW]);
    sup = match && (m_st[idx] == 2) && (op == 2'd1 || op == 2'd2);
    @(negedge clk);
    snp_valid = 1; snp_src = 2'(src); snp_op = op; snp_addr = blk;
    #1;
    chk(snp_abort == sup, {rq, " abort"}, 64'(snp_abort), 64'(sup));
    chk(snp_supply == sup, {rq, " supply"}, 64'(snp_supply), 64'(sup));
    if (sup) chk(snp_supply_data == m_dat[idx], {rq, " supply data"}, snp_supply_data, m_dat[idx]);
    if (match) begin
      if (sup) mem[int'(blk)] = m_dat[idx];
      if (op == 2'd1 && m_st[idx] == 2) m_st[idx] = 1;
      else if (op == 2'd2) m_st[idx] = 0;
    end
    @(negedge clk);
    snp_valid = 0;
  endtask

  function automatic logic [WA-1:0] wa(int tg, int idx, int sel);
    return {TAGW'(tg), IDXW'(idx), 1'(sel)};
  endfunction

  initial begin
    #(200000 * 10);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!cpu_stall && !bus_req, "R1 idle outputs after reset", {62'd0, cpu_stall, bus_req}, 0);
    chk(!snp_abort && !snp_supply, "R1 snoop outputs after reset", {62'd0, snp_abort, snp_supply}, 0);

    access(0, wa(1, 0, 0), 0);              // R1/R2 cold read miss
    access(0, wa(1, 0, 1), 0);              // R5 read hit on Shared
    access(1, wa(1, 0, 0), 32'hDEAD_0001);  // R3 write on Shared -> write miss
    access(1, wa(1, 0, 1), 32'hBEEF_0002);  // R5 write hit on Modified
    access(0, wa(1, 0, 0), 0);              // R5 read own write
    access(0, wa(2, 0, 0), 0);              // R4 dirty victim written back first
    access(1, wa(2, 1, 1), 32'h1111_2222);  // R3 write miss on Invalid line
    snoop(PEER, 2'd1, {TAGW'(2), IDXW'(1)}, "R6 snooped read on Modified");
    access(0, wa(2, 1, 0), 0);              // R6 still readable
    access(1, wa(2, 1, 0), 32'h3333_4444);  // R6 Shared -> write miss
    snoop(PEER, 2'd2, {TAGW'(2), IDXW'(1)}, "R7 snooped write on Modified");
    access(0, wa(2, 1, 1), 0);              // R7 line gone -> read miss
    snoop(PEER, 2'd2, {TAGW'(2), IDXW'(0)}, "R7 snooped write on Shared");
    access(0, wa(2, 0, 1), 0);              // R7 read miss after invalidation
    access(1, wa(3, 2, 0), 32'h5555_6666);
    snoop(ME, 2'd2, {TAGW'(3), IDXW'(2)}, "R9 own write miss observed");
    snoop(ME, 2'd1, {TAGW'(3), IDXW'(2)}, "R9 own read miss observed");
    access(1, wa(3, 2, 1), 32'h7777_8888);  // R9 line still Modified: silent hit
    snoop(PEER, 2'd1, {TAGW'(4), IDXW'(2)}, "R11 tag mismatch");
    snoop(PEER, 2'd3, {TAGW'(3), IDXW'(2)}, "R11 write-back op");
    snoop(PEER, 2'd2, {TAGW'(9), IDXW'(6)}, "R11 invalid line");
    access(0, wa(3, 2, 0), 0);              // R11 line untouched

    // R8: a foreign snoop in the cycle of a would-be hit stalls the CPU
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = wa(3, 2, 1);
    snp_valid = 1; snp_src = 2'(PEER); snp_op = 2'd1; snp_addr = {TAGW'(7), IDXW'(5)};
    #1;
    chk(cpu_stall, "R8 snoop has priority", 64'(cpu_stall), 1);
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk(!cpu_stall, "R8 hit served after snoop", 64'(cpu_stall), 0);
    chk(cpu_rdata == m_dat[2][63:32], "R8 read data after snoop", 64'(cpu_rdata), 64'(m_dat[2][63:32]));
    @(negedge clk);
    cpu_req = 0;

    lf = 16'hACE1;
    for (int n = 0; n < 120; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[6:4])
        3'd0, 3'd1, 3'd2: access(0, wa(1 + int'(lf[1:0]) % 3, int'(lf[2]), int'(lf[3])), 0);
        3'd3, 3'd4: access(1, wa(1 + int'(lf[1:0]) % 3, int'(lf[2]), int'(lf[3])), {lf, ~lf});
        3'd5: snoop(PEER, 2'd1, {TAGW'(1 + int'(lf[1:0]) % 3), IDXW'(lf[2])}, "R6 mixed read snoop");
        3'd6: snoop(PEER, 2'd2, {TAGW'(1 + int'(lf[1:0]) % 3), IDXW'(lf[2])}, "R7 mixed write snoop");
        default: snoop(lf[7] ? ME : PEER, lf[7] ? 2'd2 : 2'd3,
                       {TAGW'(1 + int'(lf[1:0]) % 3), IDXW'(lf[2])}, "R9 R11 mixed ignored snoop");
      endcase
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule